// File: doc/BRIEF.md
# Peripheral DMA Byte Packetizer

This block connects a peripheral's receive FIFO to a DMA engine. The peripheral raises a one-cycle trigger whenever it holds enough data. For each trigger the block drains a configured number of elements of a configured width from the FIFO and forwards them, one byte per beat, on a valid/ready stream. Two sideband markers travel with the stream: end-of-packet, which closes the current transfer, and end-of-line, which only asks the receiver to flush what it has buffered.

The FIFO is read in show-ahead style. Its head byte passes straight to the stream data, and a pop is issued only when the downstream side accepts that byte. The block counts bursts to place the packet boundary. A burst count of zero gives an endless stream with no packet boundary. With end-of-line marking enabled, the receiver can still write out each burst as soon as it completes. All configuration arrives on static input ports, and a synchronous clear returns the block to idle.

Top module: `pdma_byte_packetizer`

## Requirements
- R1: The element size code `c` on `cfg_elem_size` gives 2^c bytes per element (code 0 = one 8-bit byte; codes 1, 2 and 3 give 2, 4 and 8 bytes). `m_data_o` always equals the FIFO head byte `fifo_rdata_i`.
- R2: A trigger that starts a burst makes exactly `cfg_elem_cnt` elements of bytes leave on the stream, with `m_valid_o` high until the last of them is accepted. A trigger is ignored while `cfg_elem_cnt` is 0.
- R3: With `cfg_trig_cnt` = N > 0, `m_eop_o` is high on the last byte of every N-th completed burst and on no other byte.
- R4: With `cfg_trig_cnt` = 0, `m_eop_o` is never asserted.
- R5: With `cfg_eol_en` = 1, `m_eol_o` is high on the last byte of every burst, and the burst count toward the packet end continues across it. With `cfg_eol_en` = 0, `m_eol_o` stays low.
- R6: With `cfg_trig_cnt` = 1, every burst ends with `m_eop_o`.
- R7: Reset and a high `clr` each abort any burst and zero the byte counter, the burst counter, the pending flag and the overflow flag. The next burst after a clear therefore counts as the first of a packet.
- R8: A trigger that arrives during a burst is held in a one-deep pending flag. The held burst starts in the cycle after the current burst's last byte is accepted. A trigger in that same final cycle is held in the same way.
- R9: A trigger that arrives while a burst runs and the pending flag is already set is dropped and sets `ovf_o`. The flag stays set until reset or clear.
- R10: While `m_valid_o` is high and `m_ready_i` is low, the stream data and markers hold, and `fifo_pop_o` is high exactly in the cycles where a byte is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters and flags |
| cfg_elem_size | input | 2 | Element size code, 2^code bytes |
| cfg_elem_cnt | input | CNT_W | Elements per trigger |
| cfg_trig_cnt | input | TRIG_W | Bursts per packet, 0 = streaming |
| cfg_eol_en | input | 1 | Mark the last byte of each burst with end-of-line |
| trig_i | input | 1 | Peripheral trigger event |
| fifo_rdata_i | input | 8 | Head byte of the peripheral FIFO |
| fifo_pop_o | output | 1 | Pop the FIFO head |
| m_valid_o | output | 1 | Stream byte valid |
| m_ready_i | input | 1 | Stream byte ready |
| m_data_o | output | 8 | Stream byte |
| m_eop_o | output | 1 | End of packet on this byte |
| m_eol_o | output | 1 | End of line (flush) on this byte |
| ovf_o | output | 1 | Sticky trigger overflow |

## Verification
Some properties are checked by assertions on every cycle:
- the stream holds under backpressure;
- a clear empties the block;
- the overflow flag stays set;
- the overflow flag rises only after a trigger;
- streaming mode produces no end-of-packet;
- end-of-line never appears without a valid byte.

Other behaviour can only be shown by the bench's scenarios, which compare the outputs cycle by cycle against a behavioural model:
- how many bytes each element size and count yields;
- where end-of-packet falls after N bursts;
- how a queued trigger chains into the next burst;
- that the burst count starts over after a clear.

// File: rtl/pdma_byte_packetizer.sv
module pdma_byte_packetizer #(
  parameter int CNT_W  = 8,
  parameter int TRIG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [1:0]        cfg_elem_size,
  input  logic [CNT_W-1:0]  cfg_elem_cnt,
  input  logic [TRIG_W-1:0] cfg_trig_cnt,
  input  logic              cfg_eol_en,
  input  logic              trig_i,
  input  logic [7:0]        fifo_rdata_i,
  output logic              fifo_pop_o,
  output logic              m_valid_o,
  input  logic              m_ready_i,
  output logic [7:0]        m_data_o,
  output logic              m_eop_o,
  output logic              m_eol_o,
  output logic              ovf_o
);
  localparam int BW = CNT_W + 3;

  logic              busy, pend, ovf;
  logic [BW-1:0]     byte_cnt;
  logic [TRIG_W-1:0] ev_cnt;

  logic [BW-1:0] burst_len;
  logic          trig_ok, last_byte, accept, done, final_ev;

  assign burst_len = BW'(cfg_elem_cnt) << cfg_elem_size;
  assign trig_ok   = trig_i && (cfg_elem_cnt != '0);
  assign last_byte = (byte_cnt == burst_len - BW'(1));
  assign accept    = busy && m_ready_i;
  assign done      = accept && last_byte;
  assign final_ev  = (cfg_trig_cnt != '0) && (ev_cnt == cfg_trig_cnt - TRIG_W'(1));

  assign m_valid_o  = busy;
  assign m_data_o   = fifo_rdata_i;
  assign fifo_pop_o = accept;
  assign m_eop_o    = busy && last_byte && final_ev;
  assign m_eol_o    = busy && last_byte && cfg_eol_en;
  assign ovf_o      = ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      ovf      <= 1'b0;
      byte_cnt <= '0;
      ev_cnt   <= '0;
    end else if (clr) begin
      busy     <= 1'b0;
      pend     <= 1'b0;
      ovf      <= 1'b0;
      byte_cnt <= '0;
      ev_cnt   <= '0;
    end else begin
      if (accept)
        byte_cnt <= done ? '0 : byte_cnt + BW'(1);
      if (done && (cfg_trig_cnt != '0))
        ev_cnt <= final_ev ? '0 : ev_cnt + TRIG_W'(1);
      if (!busy) begin
        busy <= trig_ok;
      end else if (done) begin
        busy <= pend || trig_ok;
        pend <= pend && trig_ok;
      end else if (trig_ok) begin
        if (pend) ovf  <= 1'b1;
        else      pend <= 1'b1;
      end
    end
  end

  // R10
  hold_under_backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    (m_valid_o && !m_ready_i) |=> (m_valid_o && $stable(m_eop_o) && $stable(m_eol_o) && $stable(m_data_o)));

  // R7
  clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!m_valid_o && !ovf_o));

  // R9
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    ovf_o |=> ovf_o);

  // R9
  ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n || clr)
    $rose(ovf_o) |-> $past(trig_i));

  // R4
  stream_no_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_trig_cnt == '0) |-> !m_eop_o);

  // R5
  eol_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_eol_o || m_eop_o) |-> m_valid_o);
endmodule

// File: tb/pdma_byte_packetizer_tb.sv
`timescale 1ns/1ps
module pdma_byte_packetizer_tb;
  logic clk = 0, rst_n = 0, clr = 0;
  logic [1:0] sz = 0;
  logic [7:0] ec = 1, tc = 0;
  logic eol_en = 0, trig = 0, ready = 1;
  logic [7:0] fdata;
  logic pop, valid, eop, eol, ovf;
  logic [7:0] data;

  int checks = 0, fails = 0;
  int src_idx = 0;
  int rmode = 0;
  logic [15:0] lfsr = 16'hACE1;
  int nacc = 0, neop = 0, neol = 0;
  bit finished = 0;

  int m_busy = 0, m_left = 0, m_ev = 0, m_pend = 0, m_ovf = 0;

  always #2.5 clk = ~clk;

  assign fdata = 8'(src_idx * 37 + 5);

  pdma_byte_packetizer u_dut (
    .clk(clk), .rst_n(rst_n), .clr(clr), .cfg_elem_size(sz), .cfg_elem_cnt(ec),
    .cfg_trig_cnt(tc), .cfg_eol_en(eol_en), .trig_i(trig), .fifo_rdata_i(fdata),
    .fifo_pop_o(pop), .m_valid_o(valid), .m_ready_i(ready), .m_data_o(data),
    .m_eop_o(eop), .m_eol_o(eol), .ovf_o(ovf));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, updated on the clock edge
  always @(posedge clk) begin
    int total;
    bit acc, last, tok;
    if (!rst_n || clr) begin
      m_busy = 0; m_left = 0; m_ev = 0; m_pend = 0; m_ovf = 0;
    end else begin
      total = int'(ec) << sz;
      tok = trig && (ec != 0);
      acc = (m_busy != 0) && ready;
      last = acc && (m_left == 1);
      if (valid && ready) begin
        nacc++;
        if (eop) neop++;
        if (eol) neol++;
      end
      if (acc) begin
        src_idx++;
        m_left--;
        if (last && tc != 0) m_ev = (m_ev == int'(tc) - 1) ? 0 : m_ev + 1;
      end
      if (m_busy == 0) begin
        if (tok) begin m_busy = 1; m_left = total; end
      end else if (last) begin
        if (m_pend != 0 || tok) begin m_busy = 1; m_left = total; end
        else m_busy = 0;
        m_pend = (m_pend != 0 && tok) ? 1 : 0;
      end else if (tok) begin
        if (m_pend != 0) m_ovf = 1; else m_pend = 1;
      end
    end
  end

  // per-cycle comparison, away from the edge
  always @(posedge clk) begin
    bit e_eop, e_eol;
    #1;
    if (rst_n && !finished) begin
      e_eop = (m_busy != 0) && (m_left == 1) && (tc != 0) && (m_ev == int'(tc) - 1);
      e_eol = (m_busy != 0) && (m_left == 1) && eol_en;
      chk(valid == (m_busy != 0), "R2 valid", valid, m_busy != 0);
      chk(eop == e_eop, "R3 eop", eop, e_eop);
      chk(eol == e_eol, "R5 eol", eol, e_eol);
      chk(ovf == (m_ovf != 0), "R9 ovf", ovf, m_ovf != 0);
      chk(pop == ((m_busy != 0) && ready), "R10 pop", pop, (m_busy != 0) && ready);
      chk(data == fdata, "R1 data", data, fdata);
    end
  end

  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ready <= (rmode == 0) ? 1'b1 : (rmode == 1) ? lfsr[0] : 1'b0;
  end

  task automatic pulse;
    @(negedge clk) trig = 1;
    @(negedge clk) trig = 0;
  endtask

  task automatic idle;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (m_busy == 0 && m_pend == 0) break;
    end
  endtask

  task automatic zero;
    @(negedge clk);
    nacc = 0; neop = 0; neol = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(valid == 0 && ovf == 0 && pop == 0, "R7 reset idle", valid + ovf + pop, 0);

    // R3: 3 bytes per burst, packet after 2 bursts
    sz = 0; ec = 3; tc = 2; eol_en = 0; zero();
    pulse(); idle(); pulse(); idle();
    chk(nacc == 6, "R2 bytes", nacc, 6);
    chk(neop == 1, "R3 eop count", neop, 1);
    chk(neol == 0, "R5 eol off", neol, 0);

    // R4 and R5: streaming with eol, random backpressure
    tc = 0; eol_en = 1; rmode = 1; zero();
    for (int i = 0; i < 4; i++) begin pulse(); idle(); end
    chk(nacc == 12, "R2 stream bytes", nacc, 12);
    chk(neop == 0, "R4 no eop", neop, 0);
    chk(neol == 4, "R5 eol per burst", neol, 4);

    // R6: packet per burst, 2-byte elements
    sz = 1; ec = 2; tc = 1; eol_en = 0; rmode = 0; zero();
    for (int i = 0; i < 3; i++) begin pulse(); idle(); end
    chk(nacc == 12, "R1 2-byte elements", nacc, 12);
    chk(neop == 3, "R6 eop each burst", neop, 3);

    // R1: 4-byte elements, eol with eop on final burst
    sz = 2; ec = 1; tc = 3; eol_en = 1; rmode = 1; zero();
    for (int i = 0; i < 3; i++) begin pulse(); idle(); end
    chk(nacc == 12, "R1 4-byte elements", nacc, 12);
    chk(neop == 1, "R3 eop after 3", neop, 1);
    chk(neol == 3, "R5 eol count", neol, 3);

    // R8: trigger during burst is queued
    sz = 0; ec = 4; tc = 0; eol_en = 0; rmode = 0; zero();
    pulse(); pulse(); idle();
    chk(nacc == 8, "R8 queued burst", nacc, 8);
    chk(ovf == 0, "R8 no overflow", ovf, 0);

    // R9: third trigger overflows
    rmode = 2; zero();
    pulse(); pulse(); pulse();
    chk(ovf == 1, "R9 overflow set", ovf, 1);
    rmode = 0; idle();
    chk(nacc == 8, "R9 dropped burst", nacc, 8);
    chk(ovf == 1, "R9 sticky", ovf, 1);

    // R7: clear aborts burst, resets burst count
    tc = 2; zero();
    pulse(); idle();
    rmode = 2; pulse();
    @(negedge clk) clr = 1;
    @(negedge clk) clr = 0;
    chk(valid == 0 && ovf == 0, "R7 clear", valid + ovf, 0);
    rmode = 0; zero();
    pulse(); idle();
    chk(neop == 0, "R7 count restarted", neop, 0);
    pulse(); idle();
    chk(neop == 1, "R7 eop after two", neop, 1);

    // R2: zero element count ignores triggers
    ec = 0; zero();
    pulse(); repeat (5) @(negedge clk);
    chk(nacc == 0 && valid == 0, "R2 zero count ignored", nacc, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule